// File: doc/BRIEF.md
# UART Interrupt Identification and Status Word

This block gathers the event sources of a UART into one 32-bit status word that a host reads over a small register bus. Receive and transmit producers report FIFO level crossings, character timeouts and line errors as single-cycle pulses. Each pulse latches its own cause bit. The four modem control inputs are asynchronous levels. The block synchronises them, keeps a change flag for each line, and raises a cause bit when any of these lines moves.

The status word also shows the line status byte and the 10-bit receive fill count. The count is split: its low eight bits sit in the top byte of the word and its two high bits sit in bits 7:6. The cause bits form a bitmap, so several of them can be pending at once. The host clears causes by writing a byte to the status address, with a 1 in each bit to be cleared. A configuration byte holds the enables that decide which causes drive the single level interrupt output.

Top module: `uart_irq_status`

## Requirements
- R1: After reset the status word is zero apart from the live line status and count fields. The interrupt output is low and the configuration byte reads back as zero.
- R2: The status word is laid out as follows. Bits [4:0] hold the causes and bit 5 reads 0. Bits [7:6] hold receive count bits [9:8]. Bits [11:8] hold the change flags, and bits [15:12] hold the synchronised levels, each in the order CTS, DSR, RI, DCD from the lowest bit. Bits [23:16] hold the line status input byte and bits [31:24] hold receive count bits [7:0].
- R3: A pulse on an event input sets its cause bit after the next clock edge. The mapping is: line error to bit 0, receive data available to bit 1, character timeout to bit 2, transmit space to bit 3. Bit 4 is set by a modem line change.
- R4: Several cause bits can be pending at the same time, and each one is kept until it is acknowledged.
- R5: A write to address 0 clears each cause bit whose data bit is 1 and leaves every other cause bit unchanged. Data bits 7:6 of that write have no effect on the status word.
- R6: If a cause event arrives in the same cycle as an acknowledge of that cause bit, the bit stays set.
- R7: The configuration byte is at address 1, and its bits [3:0] are the enables. Bit 0 enables causes 1 and 2, bit 1 enables cause 3, bit 2 enables cause 0 and bit 3 enables cause 4. The interrupt output is the OR of the pending causes that are enabled. A pending cause whose enable is clear does not raise it.
- R8: The interrupt output stays high until every enabled pending cause has been cleared.
- R9: A modem input change shows up in the status word on the third clock edge after the change. At that edge three things happen: the reported level updates, the change flag for that line is set, and cause bit 4 is set.
- R10: Acknowledging cause bit 4 also clears all change flags. A flag whose line changes in that same cycle stays set, and the reported levels are not affected.
- R11: Reading address 1 returns the configuration byte in bits [7:0] with the upper bits zero. Reading address 0 returns the status word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write address: 0 acknowledges causes, 1 writes the configuration byte |
| wr_data | input | 8 | Write data byte |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 32 | Read data: status word or configuration byte |
| ev_line_err | input | 1 | Line error event pulse |
| ev_rx_avail | input | 1 | Receive level crossing pulse |
| ev_rx_timeout | input | 1 | Character timeout pulse |
| ev_tx_space | input | 1 | Transmit space available pulse |
| line_stat | input | 8 | Line status byte from the receive path |
| rx_count | input | 10 | Receive FIFO fill count |
| modem_in | input | 4 | Asynchronous modem lines {DCD, RI, DSR, CTS} |
| irq | output | 1 | Level interrupt output |

## Verification
Some properties are checked on every cycle. An event pulse always sets its cause, an acknowledge without a competing event clears the bit, and a colliding event keeps it set. The interrupt stays low while every enable is clear, and it cannot fall unless a register write takes place. Change flags survive any cycle without a modem acknowledge. Other behaviour needs the bench scenarios to show it: the exact field layout with the split count, the mapping of each enable to its causes, the three-edge latency of the modem synchroniser, and the case where a flag is cleared while a new change lands in the same cycle.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
    localparam int DATA_W   = 32;
    localparam int NCAUSE   = 5;
    localparam int NMODEM   = 4;
    localparam int NEN      = 4;
    localparam int CFG_W    = 8;
    localparam int LINE_W   = 8;
    localparam int CNT_W    = 10;
    localparam int CNT_LO_W = 8;
    localparam int CNT_HI_W = CNT_W - CNT_LO_W;

    // cause bit positions (software decodes these)
    localparam int C_LINE    = 0;
    localparam int C_RXAVAIL = 1;
    localparam int C_TIMEOUT = 2;
    localparam int C_TXSPACE = 3;
    localparam int C_MODEM   = 4;

    // enable bit positions in the configuration byte
    localparam int EN_RX    = 0;
    localparam int EN_TX    = 1;
    localparam int EN_LINE  = 2;
    localparam int EN_MODEM = 3;

    typedef struct packed {
        logic [CNT_LO_W-1:0] cnt_lo;
        logic [LINE_W-1:0]   line;
        logic [NMODEM-1:0]   lvl;
        logic [NMODEM-1:0]   delta;
        logic [CNT_HI_W-1:0] cnt_hi;
        logic                rsvd;
        logic [NCAUSE-1:0]   cause;
    } status_t;

    function automatic logic [NCAUSE-1:0] cause_mask(input logic [NEN-1:0] en);
        logic [NCAUSE-1:0] m;
        m            = '0;
        m[C_LINE]    = en[EN_LINE];
        m[C_RXAVAIL] = en[EN_RX];
        m[C_TIMEOUT] = en[EN_RX];
        m[C_TXSPACE] = en[EN_TX];
        m[C_MODEM]   = en[EN_MODEM];
        return m;
    endfunction

    function automatic status_t pack_status(
        input logic [NCAUSE-1:0] cause,
        input logic [NMODEM-1:0] delta,
        input logic [NMODEM-1:0] lvl,
        input logic [LINE_W-1:0] line,
        input logic [CNT_W-1:0]  cnt
    );
        status_t s;
        s.cause  = cause;
        s.rsvd   = 1'b0;
        s.cnt_hi = cnt[CNT_W-1:CNT_LO_W];
        s.delta  = delta;
        s.lvl    = lvl;
        s.line   = line;
        s.cnt_lo = cnt[CNT_LO_W-1:0];
        return s;
    endfunction
endpackage

// File: rtl/uis_cause_bank.sv
module uis_cause_bank #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] cause_o
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)
                cause_o[i] <= 1'b0;
            else if (set_i[i])
                cause_o[i] <= 1'b1;   // event wins over acknowledge
            else if (clr_i[i])
                cause_o[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/uis_modem_track.sv
module uis_modem_track #(
    parameter int N      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] lines_i,
    input  logic         clr_i,
    output logic [N-1:0] lvl_o,
    output logic [N-1:0] delta_o,
    output logic         change_o
);
    logic [N-1:0] sync_q [STAGES];
    logic [N-1:0] edge_w;

    assign edge_w   = sync_q[STAGES-1] ^ lvl_o;
    assign change_o = |edge_w;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < STAGES; k++) sync_q[k] <= '0;
        end else begin
            sync_q[0] <= lines_i;
            for (int k = 1; k < STAGES; k++) sync_q[k] <= sync_q[k-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_o   <= '0;
            delta_o <= '0;
        end else begin
            lvl_o   <= sync_q[STAGES-1];
            delta_o <= (delta_o & ~{N{clr_i}}) | edge_w;
        end
    end
endmodule

// File: rtl/uis_cfg_reg.sv
module uis_cfg_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_i,
    input  logic [W-1:0] data_i,
    output logic [W-1:0] cfg_o
);
    always_ff @(posedge clk) begin
        if (rst)
            cfg_o <= '0;
        else if (wr_i)
            cfg_o <= data_i;
    end
endmodule

// File: rtl/uart_irq_status.sv
module uart_irq_status
    import uart_irq_pkg::*;
#(
    parameter int ADDR_W      = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CFG_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              ev_line_err,
    input  logic              ev_rx_avail,
    input  logic              ev_rx_timeout,
    input  logic              ev_tx_space,
    input  logic [LINE_W-1:0] line_stat,
    input  logic [CNT_W-1:0]  rx_count,
    input  logic [NMODEM-1:0] modem_in,
    output logic              irq
);
    localparam logic [ADDR_W-1:0] ADDR_STAT = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] ADDR_CFG  = ADDR_W'(1);

    logic              ack_wr;
    logic              cfg_wr;
    logic [NCAUSE-1:0] clr_vec;
    logic [NCAUSE-1:0] set_vec;
    logic [NCAUSE-1:0] cause;
    logic [NMODEM-1:0] lvl;
    logic [NMODEM-1:0] delta;
    logic              modem_change;
    logic [CFG_W-1:0]  cfg_q;
    logic [NEN-1:0]    en;
    status_t           status;

    assign ack_wr  = wr_en && (wr_addr == ADDR_STAT);
    assign cfg_wr  = wr_en && (wr_addr == ADDR_CFG);
    assign clr_vec = ack_wr ? wr_data[NCAUSE-1:0] : '0;

    always_comb begin
        set_vec            = '0;
        set_vec[C_LINE]    = ev_line_err;
        set_vec[C_RXAVAIL] = ev_rx_avail;
        set_vec[C_TIMEOUT] = ev_rx_timeout;
        set_vec[C_TXSPACE] = ev_tx_space;
        set_vec[C_MODEM]   = modem_change;
    end

    uis_modem_track #(.N(NMODEM), .STAGES(SYNC_STAGES)) u_modem (
        .clk      (clk),
        .rst      (rst),
        .lines_i  (modem_in),
        .clr_i    (clr_vec[C_MODEM]),
        .lvl_o    (lvl),
        .delta_o  (delta),
        .change_o (modem_change)
    );

    uis_cause_bank #(.N(NCAUSE)) u_causes (
        .clk     (clk),
        .rst     (rst),
        .set_i   (set_vec),
        .clr_i   (clr_vec),
        .cause_o (cause)
    );

    uis_cfg_reg #(.W(CFG_W)) u_cfg (
        .clk    (clk),
        .rst    (rst),
        .wr_i   (cfg_wr),
        .data_i (wr_data),
        .cfg_o  (cfg_q)
    );

    assign en     = cfg_q[NEN-1:0];
    assign irq    = |(cause & cause_mask(en));
    assign status = pack_status(cause, delta, lvl, line_stat, rx_count);

    always_comb begin
        if (rd_addr == ADDR_STAT)
            rd_data = status;
        else if (rd_addr == ADDR_CFG)
            rd_data = {{(DATA_W-CFG_W){1'b0}}, cfg_q};
        else
            rd_data = '0;
    end
endmodule

// File: rtl/uart_irq_status_chk.sv
module uart_irq_status_chk
    import uart_irq_pkg::*;
#(
    parameter int ADDR_W = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [CFG_W-1:0]  wr_data,
    input logic              ev_line_err,
    input logic              ev_rx_avail,
    input logic              ev_tx_space,
    input logic [NCAUSE-1:0] cause,
    input logic [NEN-1:0]    en,
    input logic [NMODEM-1:0] delta,
    input logic              irq
);
    logic ack_w;
    assign ack_w = wr_en && (wr_addr == ADDR_W'(0));

    // R3
    rx_avail_set_chk: assert property (@(posedge clk) disable iff (rst)
        ev_rx_avail |=> cause[C_RXAVAIL]);

    // R5
    ack_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (ack_w && wr_data[C_LINE] && !ev_line_err) |=> !cause[C_LINE]);

    // R6
    collide_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (ack_w && wr_data[C_TXSPACE] && ev_tx_space) |=> cause[C_TXSPACE]);

    // R7
    gate_off_chk: assert property (@(posedge clk) disable iff (rst)
        (en == '0) |-> !irq);

    // R8
    irq_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (irq && !wr_en) |=> irq);

    // R10
    delta_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(ack_w && wr_data[C_MODEM]) |=> ((delta & $past(delta)) == $past(delta)));
endmodule

bind uart_irq_status uart_irq_status_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .ev_line_err (ev_line_err),
    .ev_rx_avail (ev_rx_avail),
    .ev_tx_space (ev_tx_space),
    .cause       (cause),
    .en          (en),
    .delta       (delta),
    .irq         (irq)
);

// File: tb/uart_irq_status_bench.sv
module uart_irq_status_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [1:0]  wr_addr;
    logic [7:0]  wr_data;
    logic [1:0]  rd_addr;
    logic [31:0] rd_data;
    logic        ev_line_err, ev_rx_avail, ev_rx_timeout, ev_tx_space;
    logic [7:0]  line_stat;
    logic [9:0]  rx_count;
    logic [3:0]  modem_in;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    typedef struct {
        string       req;
        string       what;
        logic [31:0] word;
        logic        irq;
    } exp_t;
    exp_t q[$];

    // reference model state
    logic [4:0] m_cause = '0;
    logic [3:0] m_delta = '0;
    logic [3:0] m_lvl   = '0;
    logic [7:0] m_cfg   = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_irq_status u_uart_irq_status (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .ev_line_err(ev_line_err),
        .ev_rx_avail(ev_rx_avail), .ev_rx_timeout(ev_rx_timeout),
        .ev_tx_space(ev_tx_space), .line_stat(line_stat), .rx_count(rx_count),
        .modem_in(modem_in), .irq(irq)
    );

    function automatic logic [31:0] model_word();
        return {rx_count[7:0], line_stat, m_lvl, m_delta, rx_count[9:8], 1'b0, m_cause};
    endfunction

    function automatic logic model_irq();
        logic [4:0] msk;
        msk = {m_cfg[3], m_cfg[1], m_cfg[0], m_cfg[0], m_cfg[2]};
        return |(m_cause & msk);
    endfunction

    task automatic expect_status(input string req, input string what);
        rd_addr = 2'd0;
        q.push_back('{req, what, model_word(), model_irq()});
    endtask

    task automatic expect_cfg(input string req, input string what);
        rd_addr = 2'd1;
        q.push_back('{req, what, {24'h0, m_cfg}, model_irq()});
    endtask

    // bit0 line err, bit1 rx avail, bit2 timeout, bit3 tx space
    task automatic pulse(input logic [3:0] ev);
        {ev_tx_space, ev_rx_timeout, ev_rx_avail, ev_line_err} = ev;
        @(negedge clk);
        {ev_tx_space, ev_rx_timeout, ev_rx_avail, ev_line_err} = '0;
        m_cause = m_cause | {1'b0, ev};
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // monitor: pops expected items and compares against the ports
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (q.size() > 0) begin
                exp_t it;
                it = q.pop_front();
                checks++;
                if (rd_data !== it.word || irq !== it.irq) begin
                    errors++;
                    $display("FAIL %s %s: rd_data=%h irq=%b expected rd_data=%h irq=%b",
                             it.req, it.what, rd_data, irq, it.word, it.irq);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
        ev_line_err = 0; ev_rx_avail = 0; ev_rx_timeout = 0; ev_tx_space = 0;
        line_stat = '0; rx_count = '0; modem_in = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        expect_status("R1", "status after reset");
        @(negedge clk);
        expect_cfg("R1", "cfg after reset");
        @(negedge clk);

        // R2 layout with split count
        rx_count = 10'h2A5; line_stat = 8'hC3;
        expect_status("R2", "count 2A5 line C3");
        @(negedge clk);
        rx_count = 10'h15A; line_stat = 8'h3C;
        expect_status("R2", "count 15A line 3C");
        @(negedge clk);

        // R3 each event sets its bit; R7 nothing enabled so irq stays low
        pulse(4'b0001); expect_status("R3", "line error cause");
        pulse(4'b0010); expect_status("R3", "rx avail cause");
        pulse(4'b0100); expect_status("R3", "timeout cause");
        pulse(4'b1000); expect_status("R3", "tx space cause, irq masked R7");
        @(negedge clk);
        expect_status("R4", "four causes held together");

        // R5 acknowledge
        bus_write(2'd0, 8'h01); m_cause = m_cause & ~5'h01;
        expect_status("R5", "ack line cause only");
        bus_write(2'd0, 8'hC0);
        expect_status("R5", "bits 7:6 of ack ignored");
        bus_write(2'd0, 8'h0E); m_cause = m_cause & ~5'h0E;
        expect_status("R5", "ack remaining causes");

        // R7 and R11 enable mapping
        bus_write(2'd1, 8'h04); m_cfg = 8'h04;
        expect_cfg("R11", "cfg readback 04");
        @(negedge clk);
        pulse(4'b0001); expect_status("R7", "line enable raises irq");
        pulse(4'b1000); expect_status("R7", "tx pending with line enable");
        bus_write(2'd0, 8'h01); m_cause = m_cause & ~5'h01;
        expect_status("R7", "tx cause masked by line-only enable");
        bus_write(2'd1, 8'h02); m_cfg = 8'h02;
        expect_status("R7", "tx enable raises irq");
        bus_write(2'd1, 8'h01); m_cfg = 8'h01;
        expect_status("R7", "rx enable, tx masked");
        pulse(4'b0100); expect_status("R7", "rx enable covers timeout");
        bus_write(2'd0, 8'h1F); m_cause = '0;
        expect_status("R5", "clear all");

        // R8 irq held until all enabled causes cleared
        bus_write(2'd1, 8'h0F); m_cfg = 8'h0F;
        expect_cfg("R11", "cfg readback 0F");
        @(negedge clk);
        pulse(4'b1010); expect_status("R8", "two causes pending");
        bus_write(2'd0, 8'h02); m_cause = m_cause & ~5'h02;
        expect_status("R8", "one cause left keeps irq");
        bus_write(2'd0, 8'h08); m_cause = m_cause & ~5'h08;
        expect_status("R8", "all cleared drops irq");

        // R6 event colliding with acknowledge
        pulse(4'b1000);
        ev_tx_space = 1'b1;
        bus_write(2'd0, 8'h08);
        ev_tx_space = 1'b0;
        expect_status("R6", "tx event wins over ack");
        bus_write(2'd0, 8'h08); m_cause = m_cause & ~5'h08;
        expect_status("R6", "later ack clears");

        // R9 modem change latency
        modem_in = 4'b0001;
        @(negedge clk);
        @(negedge clk);
        expect_status("R9", "not visible after two edges");
        @(negedge clk);
        m_lvl = 4'b0001; m_delta = 4'b0001; m_cause = m_cause | 5'h10;
        expect_status("R9", "CTS change on third edge");
        @(negedge clk);

        // R10 delta clear with modem ack
        bus_write(2'd0, 8'h10); m_delta = '0; m_cause = m_cause & ~5'h10;
        expect_status("R10", "ack clears delta, level kept");
        modem_in = 4'b0011;
        repeat (3) @(negedge clk);
        m_lvl = 4'b0011; m_delta = 4'b0010; m_cause = m_cause | 5'h10;
        expect_status("R9", "DSR change");
        @(negedge clk);
        modem_in = 4'b0111;
        @(negedge clk);
        @(negedge clk);
        bus_write(2'd0, 8'h10);
        m_lvl = 4'b0111; m_delta = 4'b0100;
        expect_status("R10", "ack with RI change in same cycle");
        bus_write(2'd0, 8'h10); m_delta = '0; m_cause = m_cause & ~5'h10;
        expect_status("R10", "final modem ack");

        @(negedge clk);
        #2;
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule